// File: doc/BRIEF.md
# Timer Time Base with Repetition Gating

This block is the counting core of a general-purpose timer. It divides the system clock by a programmable prescaler. It then steps a 16-bit counter up, down, or up-and-down (center-aligned) against an auto-reload limit. Every wrap or turning point of the counter is one over/underflow occurrence. An 8-bit repetition down-counter decides which of these occurrences become update events, so one update is produced for every N+1 occurrences.

An update event copies the buffered prescaler value and, if buffering is enabled, the buffered auto-reload value into their working copies. It also produces a one-cycle update pulse and can set a sticky update flag. Control comes from software-style strobes: register writes, enable set and clear, a generate-update command and a flag clear. A one-pulse option stops the counter at its first counter-generated update.

Top module: `tmr_timebase`

## Requirements
- R1: After reset the counter reads 0, the direction output is 0 (up), and the update pulse and update flag are both 0.
- R2: While enabled, the counter takes one step every P+1 clock cycles, where P is the working prescaler value. While disabled, the counter and the prescaler count hold.
- R3: Mode code 0 (and codes 5 to 7) counts up from 0 to the auto-reload value A and then wraps to 0. The wrap is one overflow, so a period is A+1 steps.
- R4: Mode code 1 counts down from A to 0 and then wraps to A. The wrap is one underflow, so a period is A+1 steps. The direction output is 1 in this mode.
- R5: Mode codes 2, 3 and 4 are center-aligned. The counter climbs from 0 to A and then descends to 0. Reaching A is an overflow and reaching 0 is an underflow, so each half period is A steps. The direction output is 1 while descending.
- R6: An update event comes from over/underflow only when the repetition count is 0. The repetition count then reloads with the written value N. Otherwise it decrements, so an update occurs every N+1 occurrences. A newly written N takes effect at the next reload.
- R7: A generate-update strobe produces an update pulse. It sets the counter to A in mode 1 and to 0 in all other modes, with center-aligned counting restarting upward. It also clears the prescaler count, reloads the repetition count and loads all working copies.
- R8: With the update-source select at 0, both over/underflow updates and generate-update set the update flag. With it at 1, only over/underflow updates set the flag. The update pulse is produced in both cases.
- R9: A written prescaler value takes effect only at the next update event. A generate-update after the write applies it at once.
- R10: With auto-reload buffering on, a written auto-reload value takes effect at the next update event. With buffering off, it takes effect at once.
- R11: With one-pulse mode on, the first counter-generated update clears the enable, and the counter then stays frozen.
- R12: The update flag stays set until a flag-clear strobe arrives. A set and a clear in the same cycle leave the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| countMode | input | 3 | 0 up, 1 down, 2..4 center-aligned, 5..7 up |
| arrPreloadEn | input | 1 | Buffer auto-reload writes until the next update |
| onePulseEn | input | 1 | Stop counting at the first counter-generated update |
| updReqSrc | input | 1 | 1: only over/underflow sets the update flag |
| pscWrEn | input | 1 | Prescaler write strobe |
| pscWrData | input | 16 | Prescaler write value |
| arrWrEn | input | 1 | Auto-reload write strobe |
| arrWrData | input | 16 | Auto-reload write value |
| repWrEn | input | 1 | Repetition write strobe |
| repWrData | input | 8 | Repetition write value N |
| enSet | input | 1 | Counter enable set strobe |
| enClr | input | 1 | Counter enable clear strobe |
| genUpd | input | 1 | Generate-update strobe |
| flagClr | input | 1 | Update flag clear strobe |
| count | output | 16 | Counter value |
| dirDown | output | 1 | 1 while the counter is counting down |
| updPulse | output | 1 | One-cycle update event pulse |
| updFlag | output | 1 | Sticky update flag |

## Verification
The bench measures the exact number of clock cycles between update pulses for every counting mode, with prescaler and repetition values that include an auto-reload value of 0. A half-period/full-period mix-up in center-aligned mode, or an off-by-one in the repetition reload, shows up as a wrong interval. Buffered writes to the prescaler, auto-reload and repetition values are each made just after an update, and the bench expects exactly one old-length interval before the new length appears. A design that applied them early or late would show the wrong first interval. The bench also checks that a generate-update with the update-source select at 1 pulses without raising the flag, and that one-pulse mode leaves the counter frozen at 0 instead of running on.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam logic [2:0] MODE_UP   = 3'd0;
  localparam logic [2:0] MODE_DOWN = 3'd1;
  localparam logic [2:0] MODE_CTR1 = 3'd2;
  localparam logic [2:0] MODE_CTR3 = 3'd4;

  // Strobes from the control to the datapath
  typedef struct packed {
    logic tick;        // counter step
    logic updLoad;     // update event: load working copies
    logic forceReset;  // generate-update: restart counter
  } tbStrobe_t;
endpackage

// File: rtl/tmr_datapath.sv
module tmr_datapath
  import tmr_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int PSC_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  tbStrobe_t        str,
  input  logic [2:0]       countMode,
  input  logic             arrPreloadEn,
  input  logic             arrWrEn,
  input  logic [CNT_W-1:0] arrWrData,
  input  logic             pscWrEn,
  input  logic [PSC_W-1:0] pscWrData,
  output logic [CNT_W-1:0] cnt,
  output logic             dirDown,
  output logic [PSC_W-1:0] pscAct,
  output logic             ovfEvt
);
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [CNT_W-1:0] arrPre, arrShd, arrAct, nextCnt;
  logic [PSC_W-1:0] pscPre;
  logic [CNT_W:0]   incWide;
  logic             centerDown, nextCenterDown, wrapRaw;
  logic             isDown, isCenter;

  assign isDown   = (countMode == MODE_DOWN);
  assign isCenter = (countMode >= MODE_CTR1) && (countMode <= MODE_CTR3);
  assign arrAct   = arrPreloadEn ? arrShd : arrPre;
  assign incWide  = {1'b0, cnt} + {1'b0, CNT_ONE};

  always_comb begin
    nextCnt        = cnt;
    nextCenterDown = centerDown;
    wrapRaw        = 1'b0;
    if (isCenter) begin
      if (!centerDown) begin
        if (incWide >= {1'b0, arrAct}) begin
          nextCnt        = arrAct;
          nextCenterDown = 1'b1;
          wrapRaw        = 1'b1;
        end else begin
          nextCnt = incWide[CNT_W-1:0];
        end
      end else begin
        if (cnt <= CNT_ONE) begin
          nextCnt        = '0;
          nextCenterDown = 1'b0;
          wrapRaw        = 1'b1;
        end else begin
          nextCnt = cnt - CNT_ONE;
        end
      end
    end else if (isDown) begin
      if (cnt == '0) begin
        nextCnt = arrAct;
        wrapRaw = 1'b1;
      end else begin
        nextCnt = cnt - CNT_ONE;
      end
    end else begin
      if (cnt >= arrAct) begin
        nextCnt = '0;
        wrapRaw = 1'b1;
      end else begin
        nextCnt = incWide[CNT_W-1:0];
      end
    end
  end

  assign ovfEvt  = str.tick && wrapRaw;
  assign dirDown = isDown || (isCenter && centerDown);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt        <= '0;
      centerDown <= 1'b0;
    end else if (str.forceReset) begin
      cnt        <= isDown ? arrPre : '0;
      centerDown <= 1'b0;
    end else if (str.tick) begin
      cnt        <= nextCnt;
      centerDown <= nextCenterDown;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      arrPre <= '1;
      arrShd <= '1;
      pscPre <= '0;
      pscAct <= '0;
    end else begin
      if (arrWrEn) arrPre <= arrWrData;
      if (pscWrEn) pscPre <= pscWrData;
      if (str.updLoad) begin
        arrShd <= arrPre;
        pscAct <= pscPre;
      end
    end
  end

  // R2: no step means the counter holds
  assert_hold_idle_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!str.tick && !str.forceReset) |=> $stable(cnt));

  // R7: generate-update restarts at 0 outside down mode
  assert_ug_restart_R7: assert property (@(posedge clk) disable iff (!rstN)
    (str.forceReset && !isDown) |=> (cnt == '0));

  // R4: in down mode a wrap lands on the working limit
  assert_down_wrap_R4: assert property (@(posedge clk) disable iff (!rstN)
    (ovfEvt && isDown && !str.forceReset && !str.updLoad && !arrWrEn)
      |=> (cnt == $past(arrAct)));
endmodule

// File: rtl/tmr_control.sv
module tmr_control
  import tmr_pkg::*;
#(
  parameter int PSC_W = 16,
  parameter int REP_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enSet,
  input  logic             enClr,
  input  logic             onePulseEn,
  input  logic             genUpd,
  input  logic             updReqSrc,
  input  logic             flagClr,
  input  logic             repWrEn,
  input  logic [REP_W-1:0] repWrData,
  input  logic [PSC_W-1:0] pscAct,
  input  logic             ovfEvt,
  output tbStrobe_t        str,
  output logic             cntEn,
  output logic             updPulse,
  output logic             updFlag
);
  localparam logic [PSC_W-1:0] PSC_ONE = PSC_W'(1);
  localparam logic [REP_W-1:0] REP_ONE = REP_W'(1);

  logic [PSC_W-1:0] pscCnt;
  logic [REP_W-1:0] repCnt, repPre;
  logic             tick, repZero, cntUpd, updEvt;

  assign tick    = cntEn && (pscCnt == pscAct) && !genUpd;
  assign repZero = (repCnt == '0);
  assign cntUpd  = ovfEvt && repZero;
  assign updEvt  = genUpd || cntUpd;

  assign str.tick       = tick;
  assign str.updLoad    = updEvt;
  assign str.forceReset = genUpd;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pscCnt   <= '0;
      repCnt   <= '0;
      repPre   <= '0;
      cntEn    <= 1'b0;
      updPulse <= 1'b0;
      updFlag  <= 1'b0;
    end else begin
      if (repWrEn) repPre <= repWrData;

      if (genUpd)     pscCnt <= '0;
      else if (tick)  pscCnt <= '0;
      else if (cntEn) pscCnt <= pscCnt + PSC_ONE;

      if (genUpd)       repCnt <= repPre;
      else if (ovfEvt)  repCnt <= repZero ? repPre : repCnt - REP_ONE;

      if ((cntUpd && onePulseEn) || enClr) cntEn <= 1'b0;
      else if (enSet)                      cntEn <= 1'b1;

      updPulse <= updEvt;

      if (cntUpd || (genUpd && !updReqSrc)) updFlag <= 1'b1;
      else if (flagClr)                     updFlag <= 1'b0;
    end
  end

  // R12: the flag only drops on a clear strobe
  assert_flag_sticky_R12: assert property (@(posedge clk) disable iff (!rstN)
    (updFlag && !flagClr) |=> updFlag);

  // R8: the flag only rises together with an update pulse
  assert_flag_with_pulse_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(updFlag) |-> updPulse);

  // R6: counter-driven updates need an exhausted repetition count
  assert_rep_gate_R6: assert property (@(posedge clk) disable iff (!rstN)
    updPulse |-> ($past(genUpd) || ($past(repCnt) == '0)));

  // R11: the enable drops only by a clear or in one-pulse mode
  assert_en_drop_R11: assert property (@(posedge clk) disable iff (!rstN)
    $fell(cntEn) |-> ($past(enClr) || $past(onePulseEn)));
endmodule

// File: rtl/tmr_timebase.sv
module tmr_timebase
  import tmr_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int PSC_W = 16,
  parameter int REP_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [2:0]       countMode,
  input  logic             arrPreloadEn,
  input  logic             onePulseEn,
  input  logic             updReqSrc,
  input  logic             pscWrEn,
  input  logic [PSC_W-1:0] pscWrData,
  input  logic             arrWrEn,
  input  logic [CNT_W-1:0] arrWrData,
  input  logic             repWrEn,
  input  logic [REP_W-1:0] repWrData,
  input  logic             enSet,
  input  logic             enClr,
  input  logic             genUpd,
  input  logic             flagClr,
  output logic [CNT_W-1:0] count,
  output logic             dirDown,
  output logic             updPulse,
  output logic             updFlag
);
  tbStrobe_t        str;
  logic [PSC_W-1:0] pscAct;
  logic             ovfEvt, cntEn;

  tmr_control #(.PSC_W(PSC_W), .REP_W(REP_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .enSet(enSet), .enClr(enClr),
    .onePulseEn(onePulseEn), .genUpd(genUpd), .updReqSrc(updReqSrc),
    .flagClr(flagClr), .repWrEn(repWrEn), .repWrData(repWrData),
    .pscAct(pscAct), .ovfEvt(ovfEvt), .str(str), .cntEn(cntEn),
    .updPulse(updPulse), .updFlag(updFlag)
  );

  tmr_datapath #(.CNT_W(CNT_W), .PSC_W(PSC_W)) u_dp (
    .clk(clk), .rstN(rstN), .str(str), .countMode(countMode),
    .arrPreloadEn(arrPreloadEn), .arrWrEn(arrWrEn), .arrWrData(arrWrData),
    .pscWrEn(pscWrEn), .pscWrData(pscWrData), .cnt(count),
    .dirDown(dirDown), .pscAct(pscAct), .ovfEvt(ovfEvt)
  );

  // R2: the counter never moves while disabled, except on generate-update
  assert_frozen_when_off_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!cntEn && !genUpd) |=> $stable(count));
endmodule

// File: tb/tmr_timebase_tb.sv
module tmr_timebase_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 7;
  // {mode, psc, arr, rep}
  localparam logic [31:0] VEC [NVEC] = '{
    {8'd0, 8'd0, 8'd3, 8'd0},
    {8'd0, 8'd2, 8'd4, 8'd1},
    {8'd1, 8'd1, 8'd3, 8'd0},
    {8'd2, 8'd0, 8'd4, 8'd0},
    {8'd3, 8'd1, 8'd3, 8'd1},
    {8'd4, 8'd0, 8'd5, 8'd2},
    {8'd1, 8'd0, 8'd0, 8'd0}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  countMode = '0;
  logic        arrPreloadEn = 1'b0, onePulseEn = 1'b0, updReqSrc = 1'b0;
  logic        pscWrEn = 1'b0, arrWrEn = 1'b0, repWrEn = 1'b0;
  logic [15:0] pscWrData = '0, arrWrData = '0;
  logic [7:0]  repWrData = '0;
  logic        enSet = 1'b0, enClr = 1'b0, genUpd = 1'b0, flagClr = 1'b0;
  logic [15:0] count;
  logic        dirDown, updPulse, updFlag;

  int errors = 0;
  int checks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tmr_timebase u_dut (
    .clk(clk), .rstN(rstN), .countMode(countMode), .arrPreloadEn(arrPreloadEn),
    .onePulseEn(onePulseEn), .updReqSrc(updReqSrc), .pscWrEn(pscWrEn),
    .pscWrData(pscWrData), .arrWrEn(arrWrEn), .arrWrData(arrWrData),
    .repWrEn(repWrEn), .repWrData(repWrData), .enSet(enSet), .enClr(enClr),
    .genUpd(genUpd), .flagClr(flagClr), .count(count), .dirDown(dirDown),
    .updPulse(updPulse), .updFlag(updFlag)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    pscWrEn = 1'b0; arrWrEn = 1'b0; repWrEn = 1'b0;
    enSet = 1'b0; enClr = 1'b0; genUpd = 1'b0; flagClr = 1'b0;
  endtask

  // counts clock edges until the update pulse is seen
  task automatic waitPulse(output int n);
    n = 0;
    do begin
      @(posedge clk);
      n++;
      step();
    end while (!updPulse && n < 5000);
  endtask

  initial begin
    int n;
    int hold;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 count", count, 0);
    chk("R1 dir", dirDown, 0);
    chk("R1 pulse", updPulse, 0);
    chk("R1 flag", updFlag, 0);

    for (int i = 0; i < NVEC; i++) begin
      int m, p, a, r, per, d, evts, expCnt, expDir;
      m = VEC[i][31:24]; p = VEC[i][23:16]; a = VEC[i][15:8]; r = VEC[i][7:0];
      per = (m >= 2 && m <= 4) ? a : a + 1;
      d = per * (p + 1) * (r + 1);
      evts = r + 1;
      if (m >= 2 && m <= 4) begin
        expCnt = (evts % 2 == 1) ? a : 0;
        expDir = (evts % 2 == 1) ? 1 : 0;
      end else begin
        expCnt = (m == 1) ? a : 0;
        expDir = (m == 1) ? 1 : 0;
      end
      enClr = 1'b1; step();
      countMode = 3'(m); arrPreloadEn = 1'b0; onePulseEn = 1'b0; updReqSrc = 1'b0;
      pscWrEn = 1'b1; pscWrData = 16'(p);
      arrWrEn = 1'b1; arrWrData = 16'(a);
      repWrEn = 1'b1; repWrData = 8'(r);
      step();
      genUpd = 1'b1; step();
      chk("R7 ug pulse", updPulse, 1);
      chk("R8 ug flag", updFlag, 1);
      chk("R7 ug count", count, (m == 1) ? a : 0);
      flagClr = 1'b1; step();
      chk("R12 clear", updFlag, 0);
      enSet = 1'b1; step();
      waitPulse(n);
      chk("R2 R6 first interval", n, d);
      chk("R3 R4 R5 count at update", count, expCnt);
      chk("R4 R5 dir at update", dirDown, expDir);
      chk("R6 flag on update", updFlag, 1);
      waitPulse(n);
      chk("R2 R6 second interval", n, d);
    end

    // R2: disabled counter holds
    enClr = 1'b1; step();
    hold = count;
    repeat (10) step();
    chk("R2 hold when off", count, hold);

    // R11: one-pulse stops at the first update
    countMode = 3'd0; onePulseEn = 1'b1;
    pscWrEn = 1'b1; pscWrData = 16'd0; arrWrEn = 1'b1; arrWrData = 16'd3;
    repWrEn = 1'b1; repWrData = 8'd0; step();
    genUpd = 1'b1; step();
    enSet = 1'b1; step();
    waitPulse(n);
    chk("R11 interval", n, 4);
    repeat (6) step();
    chk("R11 frozen count", count, 0);
    chk("R11 no pulse", updPulse, 0);
    onePulseEn = 1'b0;

    // R8: update-source select 1
    updReqSrc = 1'b1; flagClr = 1'b1; step();
    genUpd = 1'b1; step();
    chk("R8 ug pulse urs", updPulse, 1);
    chk("R8 ug no flag", updFlag, 0);
    enSet = 1'b1; step();
    waitPulse(n);
    chk("R8 overflow flag urs", updFlag, 1);
    updReqSrc = 1'b0;

    // R9: prescaler buffered until update
    pscWrEn = 1'b1; pscWrData = 16'd1;
    waitPulse(n);
    chk("R9 old psc interval", n, 4);
    waitPulse(n);
    chk("R9 new psc interval", n, 8);
    pscWrEn = 1'b1; pscWrData = 16'd0; step();
    genUpd = 1'b1; step();
    chk("R9 R7 ug pulse", updPulse, 1);
    waitPulse(n);
    chk("R9 immediate psc", n, 4);

    // R10: auto-reload buffering
    arrPreloadEn = 1'b1;
    arrWrEn = 1'b1; arrWrData = 16'd5;
    waitPulse(n);
    chk("R10 buffered old", n, 4);
    waitPulse(n);
    chk("R10 buffered new", n, 6);
    arrPreloadEn = 1'b0;
    arrWrEn = 1'b1; arrWrData = 16'd2;
    waitPulse(n);
    chk("R10 immediate", n, 3);

    // R6: repetition write takes effect at reload
    repWrEn = 1'b1; repWrData = 8'd2;
    waitPulse(n);
    chk("R6 old rep", n, 3);
    waitPulse(n);
    chk("R6 new rep", n, 9);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule